// File: doc/BRIEF.md
# Event-Mapped Pulse and Level Output Unit

This unit sits behind the receive path of an event distribution link. On every event-clock cycle where `ev_valid` is high it takes the 8-bit event code, looks it up in a 256-entry by 16-bit mapping table, and uses the returned word as a set of trigger bits. Low-order bits start programmable delay/width pulse channels. Some of these channels are plain and count event-clock cycles. Others count ticks of a per-channel prescaler. Further bits set or clear level outputs. The three top bits leave the block as one-cycle strobes that a timestamp latch, an event FIFO and an interrupt unit downstream can use.

Two mapping tables exist and only one is used for lookups. Software rewrites the idle table through the table write port and then requests a swap with `bank_req`. The swap is applied only on a cycle without an event, so a burst of back-to-back events always decodes from one table. Channel delay, width, polarity and prescale values are loaded through a simple word-wide register write port.

Each pulse channel is a three-state machine: CH_IDLE, CH_DELAY and CH_PULSE.
- A trigger with non-zero delay moves the channel from any state to CH_DELAY.
- A trigger with zero delay and non-zero width moves it from any state to CH_PULSE.
- A trigger with zero delay and zero width moves it from any state to CH_IDLE.
- On the last delay tick, CH_DELAY moves to CH_PULSE, or to CH_IDLE when the width is zero.
- On the last width tick, CH_PULSE moves to CH_IDLE.

The table selector is a two-state machine. BANK_LO goes to BANK_HI when `bank_req` is 1 on a cycle with no event. BANK_HI goes back to BANK_LO when `bank_req` is 0 on a cycle with no event.

Top module: `evmap_pulse_top`

## Requirements
- R1: Lookups read the table given by `active_bank` (0 or 1). Entries are written with `map_we`, where `map_bank` picks the table, `map_addr` the code and `map_wdata` the word.
- R2: A change of `bank_req` reaches `active_bank` only at a clock edge where `ev_valid` is low, one cycle later. Events on consecutive cycles all decode from the same table.
- R3: The map word takes effect on the cycle after the event. Map bits 0..3 trigger standard pulse channels 0..3. Bits 4..5 trigger prescaled channels 0..1. Bits 6..8 set level outputs 0..2. Bits 9..11 clear level outputs 0..2. A channel whose bit is 0 is not affected.
- R4: Map bit 13 drives `irq_dly_stb`, bit 14 drives `ts_latch_stb` and bit 15 drives `fifo_wr_stb`. Each strobe is high for exactly the one cycle after the event, and `fifo_code` shows that event's code during that cycle.
- R5: Consider a standard channel with delay D and width N > 0, and an event sampled at clock edge t. Its output becomes active after edge t+1+D and stays active for exactly N cycles. D = 0 gives activity right after edge t+1.
- R6: A width of 0 produces no pulse.
- R7: With the polarity bit at 1, the output is high while idle and low while the pulse is active. With the polarity bit at 0, the levels are the reverse.
- R8: A prescaled channel with prescale P counts delay and width in units of P cycles, and a value of 0 or 1 for P means 1. Its output becomes active after edge t+1+D·P and stays active for N·P cycles. The prescaler restarts at each trigger.
- R9: A trigger that arrives while a channel is delaying or pulsing restarts the delay from the new trigger. An active pulse ends at once when the new delay is non-zero.
- R10: A level output goes to 1 on its set bit and to 0 on its clear bit. When both bits arrive together, clear wins. The change is visible on the second cycle after the event.
- R11: After reset all outputs are 0, `active_bank` is 0 and every channel register is 0.
- R12: The configuration write address is channel·4 + field. Channels 0..3 are standard and 4..5 are prescaled. Field 0 is the delay (32 bits). Field 1 is the width (16 bits for standard channels, 32 bits for prescaled ones). Field 2 is the polarity (bit 0). Field 3 is the prescale (16 bits, used by prescaled channels only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event code valid this cycle |
| ev_code | input | 8 | Received event code |
| bank_req | input | 1 | Requested active mapping table |
| map_we | input | 1 | Mapping table write enable |
| map_bank | input | 1 | Table selected for the write |
| map_addr | input | 8 | Event code entry to write |
| map_wdata | input | 16 | Map word to write |
| cfg_we | input | 1 | Channel register write enable |
| cfg_addr | input | 5 | Channel·4 + field |
| cfg_wdata | input | 32 | Channel register write data |
| pulse_out | output | 4 | Standard pulse channel outputs |
| ppulse_out | output | 2 | Prescaled pulse channel outputs |
| level_out | output | 3 | Event-controlled level outputs |
| irq_dly_stb | output | 1 | Delayed interrupt request strobe |
| ts_latch_stb | output | 1 | Timestamp latch strobe |
| fifo_wr_stb | output | 1 | Event FIFO write strobe |
| fifo_code | output | 8 | Code belonging to the current strobe |
| active_bank | output | 1 | Table used for lookups |

## Verification
The bench builds the block with its default parameters: four standard channels, two prescaled channels, three levels, a 32-bit delay and 16-bit prescale. It loads small delays, widths and prescales (0 to 5), so each pulse edge, the zero-delay and zero-width boundaries and an inverted channel fall within a few dozen cycles. A prescale of 4 separates tick counting from cycle counting, and a prescale of 0 checks the treat-as-one rule. A retrigger in mid-pulse, a table swap requested inside a two-event burst and a set-with-clear entry cover the ordering rules.

// File: rtl/evmap_pkg.sv
`timescale 1ns/1ps
package evmap_pkg;
    localparam int CODE_W   = 8;
    localparam int MAP_W    = 16;
    localparam int BIT_IRQ  = 13;
    localparam int BIT_TS   = 14;
    localparam int BIT_FIFO = 15;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_DELAY = 2'd1,
        CH_PULSE = 2'd2
    } chan_state_t;

    typedef enum logic {
        BANK_LO = 1'b0,
        BANK_HI = 1'b1
    } bank_state_t;
endpackage

// File: rtl/evmap_table.sv
`timescale 1ns/1ps
module evmap_table
    import evmap_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int MW = MAP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_valid,
    input  logic [CW-1:0] ev_code,
    input  logic          bank_req,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [CW-1:0] wr_addr,
    input  logic [MW-1:0] wr_data,
    output logic          map_vld,
    output logic [MW-1:0] map_word,
    output logic [CW-1:0] map_code,
    output logic          active_bank
);
    localparam int DEPTH = 1 << CW;

    logic [MW-1:0] mem [0:2*DEPTH-1];
    bank_state_t   bank_q, bank_d;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wr_bank, wr_addr}] <= wr_data;
        end
    end

    // table selector: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= BANK_LO;
        else        bank_q <= bank_d;
    end

    // table selector: transitions, only on event-free cycles
    always_comb begin
        bank_d = bank_q;
        if (!ev_valid) begin
            unique case (bank_q)
                BANK_LO: if (bank_req)  bank_d = BANK_HI;
                BANK_HI: if (!bank_req) bank_d = BANK_LO;
            endcase
        end
    end

    assign active_bank = (bank_q == BANK_HI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_vld  <= 1'b0;
            map_word <= '0;
            map_code <= '0;
        end else begin
            map_vld <= ev_valid;
            if (ev_valid) begin
                map_word <= mem[{active_bank, ev_code}];
                map_code <= ev_code;
            end
        end
    end

    // R2
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> $stable(active_bank));
endmodule

// File: rtl/evmap_pulse_chan.sv
`timescale 1ns/1ps
module evmap_pulse_chan
    import evmap_pkg::*;
#(
    parameter int DLY_W = 32,
    parameter int WID_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [DLY_W-1:0] delay_i,
    input  logic [WID_W-1:0] width_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic             pol_i,
    output logic             pulse_o
);
    localparam int CNT_W = (DLY_W > WID_W) ? DLY_W : WID_W;

    chan_state_t      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PSC_W-1:0] pcnt_q;
    logic [PSC_W-1:0] psc_eff;
    logic             tick;

    assign psc_eff = (psc_i <= PSC_W'(1)) ? PSC_W'(1) : psc_i;
    assign tick    = (pcnt_q == (psc_eff - PSC_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pcnt_q <= '0;
        else if (trig) pcnt_q <= '0;
        else if (tick) pcnt_q <= '0;
        else           pcnt_q <= pcnt_q + PSC_W'(1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CH_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (trig) begin
            if (delay_i != '0) begin
                st_d  = CH_DELAY;
                cnt_d = CNT_W'(delay_i) - CNT_W'(1);
            end else if (width_i != '0) begin
                st_d  = CH_PULSE;
                cnt_d = CNT_W'(width_i) - CNT_W'(1);
            end else begin
                st_d  = CH_IDLE;
            end
        end else if (tick) begin
            unique case (st_q)
                CH_IDLE: begin
                    st_d = CH_IDLE;
                end
                CH_DELAY: begin
                    if (cnt_q != '0) begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end else if (width_i != '0) begin
                        st_d  = CH_PULSE;
                        cnt_d = CNT_W'(width_i) - CNT_W'(1);
                    end else begin
                        st_d  = CH_IDLE;
                    end
                end
                CH_PULSE: begin
                    if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
                    else             st_d  = CH_IDLE;
                end
                default: st_d = CH_IDLE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_o <= 1'b0;
        else        pulse_o <= (st_d == CH_PULSE) ^ pol_i;
    end

    // R5
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == CH_PULSE) |-> ($past(trig) || $past(st_q == CH_DELAY)));
    // R6
    zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && delay_i == '0 && width_i == '0) |=> (st_q == CH_IDLE));
    // R9
    retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && delay_i != '0) |=> (pulse_o == pol_i));
endmodule

// File: rtl/evmap_level.sv
`timescale 1ns/1ps
module evmap_level #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] lvl_o
);
    for (genvar i = 0; i < N; i++) begin : g_lvl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        lvl_o[i] <= 1'b0;
            else if (clr_v[i]) lvl_o[i] <= 1'b0;
            else if (set_v[i]) lvl_o[i] <= 1'b1;
        end
    end

    // R10
    lvl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v != '0) |=> ((lvl_o & $past(clr_v)) == '0));
    // R10
    lvl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_v & ~clr_v) != '0) |=> ((lvl_o & $past(set_v & ~clr_v)) == $past(set_v & ~clr_v)));
endmodule

// File: rtl/evmap_pulse_top.sv
`timescale 1ns/1ps
module evmap_pulse_top
    import evmap_pkg::*;
#(
    parameter int N_STD = 4,
    parameter int N_PRE = 2,
    parameter int N_LVL = 3,
    parameter int STD_WID_W = 16,
    parameter int PRE_WID_W = 32,
    parameter int DLY_W = 32,
    parameter int PSC_W = 16,
    localparam int N_CH = N_STD + N_PRE,
    localparam int CFG_AW = $clog2(N_CH * 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [CODE_W-1:0] ev_code,
    input  logic              bank_req,
    input  logic              map_we,
    input  logic              map_bank,
    input  logic [CODE_W-1:0] map_addr,
    input  logic [MAP_W-1:0]  map_wdata,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DLY_W-1:0]  cfg_wdata,
    output logic [N_STD-1:0]  pulse_out,
    output logic [N_PRE-1:0]  ppulse_out,
    output logic [N_LVL-1:0]  level_out,
    output logic              irq_dly_stb,
    output logic              ts_latch_stb,
    output logic              fifo_wr_stb,
    output logic [CODE_W-1:0] fifo_code,
    output logic              active_bank
);
    localparam int CH_W     = CFG_AW - 2;
    localparam int PRE_BASE = N_STD;
    localparam int SET_BASE = N_STD + N_PRE;
    localparam int CLR_BASE = SET_BASE + N_LVL;
    localparam int SPARE_LO = CLR_BASE + N_LVL;

    logic              map_vld;
    logic [MAP_W-1:0]  map_word;
    logic [CODE_W-1:0] map_code;

    logic [DLY_W-1:0]     dly_r [N_CH];
    logic [PRE_WID_W-1:0] wid_r [N_CH];
    logic [PSC_W-1:0]     psc_r [N_CH];
    logic [N_CH-1:0]      pol_r;

    logic [CH_W-1:0] wr_ch;
    logic [1:0]      wr_fld;

    assign wr_ch  = cfg_addr[CFG_AW-1:2];
    assign wr_fld = cfg_addr[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CH; i++) begin
                dly_r[i] <= '0;
                wid_r[i] <= '0;
                psc_r[i] <= '0;
            end
            pol_r <= '0;
        end else if (cfg_we && (int'(wr_ch) < N_CH)) begin
            unique case (wr_fld)
                2'd0: dly_r[wr_ch] <= cfg_wdata;
                2'd1: wid_r[wr_ch] <= PRE_WID_W'(cfg_wdata);
                2'd2: pol_r[wr_ch] <= cfg_wdata[0];
                2'd3: psc_r[wr_ch] <= cfg_wdata[PSC_W-1:0];
            endcase
        end
    end

    evmap_table #(.CW(CODE_W), .MW(MAP_W)) table_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_valid    (ev_valid),
        .ev_code     (ev_code),
        .bank_req    (bank_req),
        .wr_en       (map_we),
        .wr_bank     (map_bank),
        .wr_addr     (map_addr),
        .wr_data     (map_wdata),
        .map_vld     (map_vld),
        .map_word    (map_word),
        .map_code    (map_code),
        .active_bank (active_bank)
    );

    for (genvar i = 0; i < N_STD; i++) begin : g_std
        evmap_pulse_chan #(.DLY_W(DLY_W), .WID_W(STD_WID_W), .PSC_W(PSC_W)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .trig    (map_vld & map_word[i]),
            .delay_i (dly_r[i]),
            .width_i (wid_r[i][STD_WID_W-1:0]),
            .psc_i   (PSC_W'(0)),
            .pol_i   (pol_r[i]),
            .pulse_o (pulse_out[i])
        );
    end

    for (genvar j = 0; j < N_PRE; j++) begin : g_pre
        evmap_pulse_chan #(.DLY_W(DLY_W), .WID_W(PRE_WID_W), .PSC_W(PSC_W)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .trig    (map_vld & map_word[PRE_BASE+j]),
            .delay_i (dly_r[N_STD+j]),
            .width_i (wid_r[N_STD+j]),
            .psc_i   (psc_r[N_STD+j]),
            .pol_i   (pol_r[N_STD+j]),
            .pulse_o (ppulse_out[j])
        );
    end

    evmap_level #(.N(N_LVL)) level_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (map_word[SET_BASE +: N_LVL] & {N_LVL{map_vld}}),
        .clr_v (map_word[CLR_BASE +: N_LVL] & {N_LVL{map_vld}}),
        .lvl_o (level_out)
    );

    if (SPARE_LO < BIT_IRQ) begin : g_spare
        logic unused_spare_bits;
        assign unused_spare_bits = ^map_word[BIT_IRQ-1:SPARE_LO];
    end

    assign irq_dly_stb  = map_vld & map_word[BIT_IRQ];
    assign ts_latch_stb = map_vld & map_word[BIT_TS];
    assign fifo_wr_stb  = map_vld & map_word[BIT_FIFO];
    assign fifo_code    = map_code;

    // R4
    fifo_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_stb |-> $past(ev_valid));
    // R4
    ts_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_latch_stb && !ev_valid) |=> !ts_latch_stb);
endmodule

// File: tb/evmap_pulse_top_tb_top.sv
`timescale 1ns/1ps
module evmap_pulse_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [7:0]  ev_code = '0;
    logic        bank_req = 1'b0;
    logic        map_we = 1'b0;
    logic        map_bank = 1'b0;
    logic [7:0]  map_addr = '0;
    logic [15:0] map_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  pulse_out;
    logic [1:0]  ppulse_out;
    logic [2:0]  level_out;
    logic        irq_dly_stb, ts_latch_stb, fifo_wr_stb, active_bank;
    logic [7:0]  fifo_code;

    evmap_pulse_top dut_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
        .bank_req(bank_req), .map_we(map_we), .map_bank(map_bank),
        .map_addr(map_addr), .map_wdata(map_wdata), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pulse_out(pulse_out),
        .ppulse_out(ppulse_out), .level_out(level_out),
        .irq_dly_stb(irq_dly_stb), .ts_latch_stb(ts_latch_stb),
        .fifo_wr_stb(fifo_wr_stb), .fifo_code(fifo_code),
        .active_bank(active_bank)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        int    sig;
        int    mask;
        int    exp;
        string tag;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    function automatic void push(int at, int sig, int mask, int exp, string tag);
        item_t it;
        int k;
        it.at = at; it.sig = sig; it.mask = mask; it.exp = exp; it.tag = tag;
        k = q.size();
        while (k > 0 && q[k-1].at > at) k--;
        q.insert(k, it);
    endfunction

    function automatic int observe(int sig);
        case (sig)
            0: return 32'(pulse_out);
            1: return 32'(ppulse_out);
            2: return 32'(level_out);
            3: return 32'({fifo_wr_stb, ts_latch_stb, irq_dly_stb});
            4: return 32'(fifo_code);
            default: return 32'(active_bank);
        endcase
    endfunction

    // monitor: pops expected items as their cycle arrives
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].at <= cyc) begin
                item_t it;
                int obs;
                it  = q.pop_front();
                obs = observe(it.sig);
                n_cmp++;
                if (((obs & it.mask) != (it.exp & it.mask)) || (it.at != cyc)) begin
                    n_bad++;
                    $display("FAIL %s cyc=%0d sig=%0d actual=%h expected=%h", it.tag,
                             it.at, it.sig, obs & it.mask, it.exp & it.mask);
                end
            end
        end
    end

    task automatic cfg_wr(int ch, int fld, int val);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_addr = 5'(ch * 4 + fld); cfg_wdata = 32'(val);
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic map_wr(bit bank, int code, int word);
        @(posedge clk); #2;
        map_we = 1'b1; map_bank = bank; map_addr = 8'(code); map_wdata = 16'(word);
        @(posedge clk); #2;
        map_we = 1'b0;
    endtask

    task automatic fire(int code, output int c);
        @(posedge clk); #2;
        ev_valid = 1'b1; ev_code = 8'(code); c = cyc;
        @(posedge clk); #2;
        ev_valid = 1'b0;
    endtask

    task automatic expect_pulse(int sig, int b, int c, int dp, int np, bit pol, string tag);
        int m;
        int idle;
        int act;
        m    = 1 << b;
        idle = pol ? m : 0;
        act  = pol ? 0 : m;
        push(c + 1 + dp,      sig, m, idle, tag);
        push(c + 2 + dp,      sig, m, act,  tag);
        push(c + 1 + dp + np, sig, m, act,  tag);
        push(c + 2 + dp + np, sig, m, idle, tag);
    endtask

    task automatic idle_wait(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        int c;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        c = cyc;
        // R11: everything clear after reset
        for (int s = 0; s < 6; s++) push(c + 1, s, -1, 0, "R11");
        idle_wait(3);

        // R1 R12: table bank 0 and 1 contents, channel registers
        map_wr(0, 'h10, 'h0001);
        map_wr(0, 'h11, 'hE002);
        map_wr(0, 'h12, 'h0004);
        map_wr(0, 'h13, 'h0008);
        map_wr(0, 'h14, 'h0010);
        map_wr(0, 'h15, 'h0020);
        map_wr(0, 'h20, 'h00C0);
        map_wr(0, 'h21, 'h0200);
        map_wr(0, 'h22, 'h0900);
        map_wr(0, 'h23, 'h0100);
        map_wr(1, 'h10, 'h0002);
        cfg_wr(0, 0, 3); cfg_wr(0, 1, 5);
        cfg_wr(1, 0, 0); cfg_wr(1, 1, 1);
        cfg_wr(2, 0, 2); cfg_wr(2, 1, 0);
        cfg_wr(3, 0, 1); cfg_wr(3, 1, 2); cfg_wr(3, 2, 1);
        cfg_wr(4, 0, 2); cfg_wr(4, 1, 3); cfg_wr(4, 3, 4);
        cfg_wr(5, 0, 0); cfg_wr(5, 1, 2); cfg_wr(5, 3, 0);
        idle_wait(2);
        // R7: inverted channel idles high
        push(cyc + 1, 0, 'h8, 'h8, "R7");
        idle_wait(2);

        // R5 R12: delay 3, width 5
        fire('h10, c);
        expect_pulse(0, 0, c, 3, 5, 0, "R5");
        idle_wait(14);

        // R4 strobes, R5 zero delay with width 1, R3 other channels untouched
        fire('h11, c);
        push(c + 1, 3, 7, 7, "R4");
        push(c + 1, 4, 'hFF, 'h11, "R4");
        push(c + 2, 3, 7, 0, "R4");
        expect_pulse(0, 1, c, 0, 1, 0, "R5");
        push(c + 2, 0, 'h5, 0, "R3");
        idle_wait(8);

        // R6: width 0 gives nothing
        fire('h12, c);
        for (int k = 1; k <= 8; k++) push(c + k, 0, 'h4, 0, "R6");
        idle_wait(10);

        // R7: inverted pulse, delay 1 width 2
        fire('h13, c);
        expect_pulse(0, 3, c, 1, 2, 1, "R7");
        idle_wait(8);

        // R8: prescale 4, delay 2, width 3
        fire('h14, c);
        expect_pulse(1, 0, c, 8, 12, 0, "R8");
        idle_wait(26);
        // R8: prescale 0 behaves as 1
        fire('h15, c);
        expect_pulse(1, 1, c, 0, 2, 0, "R8");
        idle_wait(8);

        // R9: retrigger during pulse, second event at c+6
        fire('h10, c);
        push(c + 5,  0, 1, 1, "R9");
        push(c + 7,  0, 1, 1, "R9");
        push(c + 8,  0, 1, 0, "R9");
        push(c + 10, 0, 1, 0, "R9");
        push(c + 11, 0, 1, 1, "R9");
        push(c + 15, 0, 1, 1, "R9");
        push(c + 16, 0, 1, 0, "R9");
        idle_wait(4);
        fire('h10, c);
        idle_wait(14);

        // R10: levels
        fire('h20, c); push(c + 2, 2, 7, 3, "R10");
        fire('h23, c); push(c + 2, 2, 7, 7, "R10");
        fire('h21, c); push(c + 2, 2, 7, 6, "R10");
        fire('h22, c); push(c + 2, 2, 7, 2, "R10");
        idle_wait(4);

        // R2: swap requested inside a two-event burst
        @(posedge clk); #2;
        ev_valid = 1'b1; ev_code = 8'h10; bank_req = 1'b1; c = cyc;
        push(c + 1, 5, 1, 0, "R2");
        push(c + 2, 5, 1, 0, "R2");
        push(c + 3, 5, 1, 1, "R2");
        push(c + 3, 0, 2, 0, "R2");
        push(c + 5, 0, 1, 0, "R9");
        push(c + 6, 0, 1, 1, "R2");
        @(posedge clk); #2;
        @(posedge clk); #2;
        ev_valid = 1'b0;
        idle_wait(16);

        // R1: bank 1 entry now used
        fire('h10, c);
        expect_pulse(0, 1, c, 0, 1, 0, "R1");
        push(c + 2, 0, 1, 0, "R1");
        idle_wait(6);

        while (q.size() > 0) @(posedge clk);
        idle_wait(2);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog cyc=%0d actual=running expected=finished", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule